// File: doc/BRIEF.md
# Open-Page DRAM Bank Command Sequencer

This block sits between an in-order request stream and the shared command bus of a multi-bank DRAM device. It keeps the last opened row of every bank open and remembers, per bank, whether a row is open and which one. For each incoming read or write it picks one of three command sequences. A request to the row that is already open gets a column command alone. A request to a bank with no open row gets an activate followed by the column command. A request to a bank holding a different row gets a precharge, then an activate, then the column command.

Requests use a valid/ready handshake carrying bank, row, column and a write flag. The request must be held until it is accepted. It is accepted in the cycle the sequencer decides its column command, and requests are served strictly in arrival order. Three timing gaps, counted in cycles, are runtime inputs: activate to column, precharge to activate, and activate to precharge on the same bank. The sequencer issues no command on a bank until the relevant gap has passed, and holds the request meanwhile. Each column command carries an outcome code that tells which of the three sequences was used. The code is based on the bank state when the request was first seen.

Top module: `dram_bank_seq`

## Requirements
- R1: A request to a bank with no open row produces an activate (op 1) for its row, then its column command. The column command carries outcome 2 (empty).
- R2: A request whose row equals the open row of its bank produces only the column command: read op 3 when write flag is 0, write op 4 when it is 1. It carries outcome 1 (hit).
- R3: A request to a bank holding a different open row produces a precharge (op 2), then an activate, then the column command. The column command carries outcome 3 (conflict).
- R4: Every command carries the bank, row and column of the request being served. An activate opens its row in that bank only, and a precharge closes that bank only.
- R5: At most one command is issued per cycle across all banks. When no command is issued, cmd_valid_o is 0 and op, bank, row, column and outcome are all 0. Outcome is 0 on every non-column command.
- R6: A column command on a bank is decided no fewer than max(t_rcd_i,1) cycles after the activate on that bank.
- R7: An activate on a bank is decided no fewer than max(t_rp_i,1) cycles after the last precharge on that bank.
- R8: A precharge on a bank is decided no fewer than max(t_ras_i,1) cycles after the last activate on that bank.
- R9: req_ready_o is 1 only while req_valid_i is 1, and only in the cycle the column command for the request is decided. Each command appears on the outputs one cycle after its decision, in request order.
- R10: After reset, all banks are closed, no command is issued, and req_ready_o is 0 until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| t_rcd_i | input | TIMER_W | Minimum cycles from activate to column command |
| t_rp_i | input | TIMER_W | Minimum cycles from precharge to activate |
| t_ras_i | input | TIMER_W | Minimum cycles from activate to precharge |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| req_write_i | input | 1 | 1 = write, 0 = read |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_op_o | output | 3 | 0 none, 1 activate, 2 precharge, 3 read, 4 write |
| cmd_bank_o | output | BANK_W | Command bank |
| cmd_row_o | output | ROW_W | Command row |
| cmd_col_o | output | COL_W | Command column |
| outcome_o | output | 2 | On column commands: 1 hit, 2 empty, 3 conflict; otherwise 0 |

## Verification
A stale or corrupted open-row entry shows at the ports in the next command issued to that bank. A missing precharge, a spurious activate, or a wrong outcome code then appears within one cycle of the decision. A timing counter that runs short or long moves an activate, precharge or column command by at least one cycle, so the behavioural model of open rows and last-command times catches it on the very cycle it drifts. Mixing random banks over a small row set, with idle cycles in between, puts hit, empty and conflict sequences under each of three timing settings, including zero gaps.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_PRE = 3'd2,
    OP_RD  = 3'd3,
    OP_WR  = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    OC_NONE     = 2'd0,
    OC_HIT      = 2'd1,
    OC_EMPTY    = 2'd2,
    OC_CONFLICT = 2'd3
  } outcome_e;
endpackage

// File: rtl/dram_bank_state.sv
module dram_bank_state #(
  parameter int ROW_W   = 8,
  parameter int TIMER_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               act_i,
  input  logic               pre_i,
  input  logic               col_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [TIMER_W-1:0] t_rcd_i,
  input  logic [TIMER_W-1:0] t_rp_i,
  input  logic [TIMER_W-1:0] t_ras_i,
  output logic               open_o,
  output logic [ROW_W-1:0]   row_o,
  output logic               rcd_ok_o,
  output logic               rp_ok_o,
  output logic               ras_ok_o
);
  localparam logic [TIMER_W-1:0] CNT_MAX = '1;
  localparam logic [TIMER_W-1:0] CNT_ONE = TIMER_W'(1);

  logic               open_q;
  logic [ROW_W-1:0]   row_q;
  logic [TIMER_W-1:0] act_cnt_q, pre_cnt_q;

  // counters hold cycles since last act / pre, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      row_q     <= '0;
      act_cnt_q <= CNT_MAX;
      pre_cnt_q <= CNT_MAX;
    end else begin
      if (act_i) begin
        open_q    <= 1'b1;
        row_q     <= row_i;
        act_cnt_q <= CNT_ONE;
      end else if (act_cnt_q != CNT_MAX) begin
        act_cnt_q <= act_cnt_q + CNT_ONE;
      end
      if (pre_i) begin
        open_q    <= 1'b0;
        pre_cnt_q <= CNT_ONE;
      end else if (pre_cnt_q != CNT_MAX) begin
        pre_cnt_q <= pre_cnt_q + CNT_ONE;
      end
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign rcd_ok_o = act_cnt_q >= t_rcd_i;
  assign rp_ok_o  = pre_cnt_q >= t_rp_i;
  assign ras_ok_o = act_cnt_q >= t_ras_i;

  assert_rcd_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_i |-> (open_q && act_cnt_q >= t_rcd_i));
  assert_rp_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> (!open_q && pre_cnt_q >= t_rp_i));
  assert_ras_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> (open_q && act_cnt_q >= t_ras_i));
  assert_act_opens_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (open_q && row_q == $past(row_i)));
endmodule

// File: rtl/dram_cmd_sel.sv
module dram_cmd_sel
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                            req_valid_i,
  input  logic [BANK_W-1:0]               req_bank_i,
  input  logic [ROW_W-1:0]                req_row_i,
  input  logic [NUM_BANKS-1:0]            open_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] row_i,
  input  logic [NUM_BANKS-1:0]            rcd_ok_i,
  input  logic [NUM_BANKS-1:0]            rp_ok_i,
  input  logic [NUM_BANKS-1:0]            ras_ok_i,
  output logic                            act_o,
  output logic                            pre_o,
  output logic                            col_o,
  output logic [1:0]                      fresh_outcome_o
);
  logic bank_open, row_match;

  assign bank_open = open_i[req_bank_i];
  assign row_match = bank_open && (row_i[req_bank_i] == req_row_i);

  always_comb begin
    act_o = 1'b0;
    pre_o = 1'b0;
    col_o = 1'b0;
    if (req_valid_i) begin
      if (row_match)      col_o = rcd_ok_i[req_bank_i];
      else if (!bank_open) act_o = rp_ok_i[req_bank_i];
      else                pre_o = ras_ok_i[req_bank_i];
    end
  end

  always_comb begin
    if (row_match)       fresh_outcome_o = OC_HIT;
    else if (!bank_open) fresh_outcome_o = OC_EMPTY;
    else                 fresh_outcome_o = OC_CONFLICT;
  end
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int TIMER_W   = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TIMER_W-1:0] t_rcd_i,
  input  logic [TIMER_W-1:0] t_rp_i,
  input  logic [TIMER_W-1:0] t_ras_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [BANK_W-1:0]  req_bank_i,
  input  logic [ROW_W-1:0]   req_row_i,
  input  logic [COL_W-1:0]   req_col_i,
  input  logic               req_write_i,
  output logic               cmd_valid_o,
  output logic [2:0]         cmd_op_o,
  output logic [BANK_W-1:0]  cmd_bank_o,
  output logic [ROW_W-1:0]   cmd_row_o,
  output logic [COL_W-1:0]   cmd_col_o,
  output logic [1:0]         outcome_o
);
  logic [NUM_BANKS-1:0]            bank_open, rcd_ok, rp_ok, ras_ok;
  logic [NUM_BANKS-1:0]            bank_act, bank_pre, bank_col;
  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
  logic                            act_fire, pre_fire, col_fire;
  logic [1:0]                      fresh_oc, cur_oc, cls_q;
  logic                            busy_q;

  for (genvar bk = 0; bk < NUM_BANKS; bk++) begin : g_bank
    logic sel;
    assign sel          = (req_bank_i == BANK_W'(bk));
    assign bank_act[bk] = act_fire && sel;
    assign bank_pre[bk] = pre_fire && sel;
    assign bank_col[bk] = col_fire && sel;

    dram_bank_state #(.ROW_W(ROW_W), .TIMER_W(TIMER_W)) u_state (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (bank_act[bk]),
      .pre_i    (bank_pre[bk]),
      .col_i    (bank_col[bk]),
      .row_i    (req_row_i),
      .t_rcd_i  (t_rcd_i),
      .t_rp_i   (t_rp_i),
      .t_ras_i  (t_ras_i),
      .open_o   (bank_open[bk]),
      .row_o    (bank_row[bk]),
      .rcd_ok_o (rcd_ok[bk]),
      .rp_ok_o  (rp_ok[bk]),
      .ras_ok_o (ras_ok[bk])
    );
  end

  dram_cmd_sel #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_sel (
    .req_valid_i     (req_valid_i),
    .req_bank_i      (req_bank_i),
    .req_row_i       (req_row_i),
    .open_i          (bank_open),
    .row_i           (bank_row),
    .rcd_ok_i        (rcd_ok),
    .rp_ok_i         (rp_ok),
    .ras_ok_i        (ras_ok),
    .act_o           (act_fire),
    .pre_o           (pre_fire),
    .col_o           (col_fire),
    .fresh_outcome_o (fresh_oc)
  );

  assign req_ready_o = col_fire;
  // outcome frozen at first sight of the request
  assign cur_oc = busy_q ? cls_q : fresh_oc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cls_q  <= OC_NONE;
    end else if (req_valid_i) begin
      busy_q <= !col_fire;
      if (!busy_q) cls_q <= fresh_oc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= OP_NOP;
      cmd_bank_o  <= '0;
      cmd_row_o   <= '0;
      cmd_col_o   <= '0;
      outcome_o   <= OC_NONE;
    end else begin
      cmd_valid_o <= act_fire | pre_fire | col_fire;
      cmd_bank_o  <= '0;
      cmd_row_o   <= '0;
      cmd_col_o   <= '0;
      outcome_o   <= OC_NONE;
      if (act_fire)      cmd_op_o <= OP_ACT;
      else if (pre_fire) cmd_op_o <= OP_PRE;
      else if (col_fire) cmd_op_o <= req_write_i ? OP_WR : OP_RD;
      else               cmd_op_o <= OP_NOP;
      if (act_fire | pre_fire | col_fire) begin
        cmd_bank_o <= req_bank_i;
        cmd_row_o  <= req_row_i;
        cmd_col_o  <= req_col_i;
      end
      if (col_fire) outcome_o <= cur_oc;
    end
  end

  assert_one_cmd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bank_act, bank_pre, bank_col}));
  assert_ready_needs_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> req_valid_i);
  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !cmd_valid_o && outcome_o == OC_NONE);
  assert_hit_no_act_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_fire && cur_oc == OC_HIT && !busy_q) |-> $past(!req_valid_i || col_fire));
endmodule

// File: tb/dram_bank_seq_tb.sv
module dram_bank_seq_tb;
  localparam int NB = 4, RW = 8, CW = 6, TW = 4, BW = 2;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic [TW-1:0] t_rcd_i = '0, t_rp_i = '0, t_ras_i = '0;
  logic          req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [BW-1:0] req_bank_i = '0;
  logic [RW-1:0] req_row_i = '0;
  logic [CW-1:0] req_col_i = '0;
  logic          req_ready_o, cmd_valid_o;
  logic [2:0]    cmd_op_o;
  logic [BW-1:0] cmd_bank_o;
  logic [RW-1:0] cmd_row_o;
  logic [CW-1:0] cmd_col_o;
  logic [1:0]    outcome_o;

  always #10 clk_i = ~clk_i;

  dram_bank_seq #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .TIMER_W(TW)) u_dut (.*);

  typedef struct { int bank; int row; int col; int wr; } req_s;
  req_s q[$];

  int vectors = 0, fails = 0;
  bit done = 0;
  int cyc = 0;
  bit m_open [NB];
  int m_row [NB], m_lact [NB], m_lpre [NB];
  bit m_first = 1;
  int m_cls = 0;
  int e_valid = 0, e_op = 0, e_bank = 0, e_row = 0, e_col = 0, e_oc = 0;
  int seen_hit = 0, seen_empty = 0, seen_conf = 0;

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      1: return "R7 activate";
      2: return "R8 precharge";
      3, 4: return "R6 column";
      default: return "R5 idle";
    endcase
  endfunction

  function automatic string oc_tag(input int oc);
    case (oc)
      1: return "R2 hit outcome";
      2: return "R1 empty outcome";
      3: return "R3 conflict outcome";
      default: return "R5 outcome zero";
    endcase
  endfunction

  task automatic step(input bit allow_idle);
    bit v;
    int b, e_rdy;
    @(negedge clk_i);
    // compare command decided at previous edge
    check(op_tag(e_op), int'(cmd_op_o), e_op);
    check("R5 cmd_valid", int'(cmd_valid_o), e_valid);
    check("R4 cmd_bank", int'(cmd_bank_o), e_bank);
    check("R4 cmd_row", int'(cmd_row_o), e_row);
    check("R4 cmd_col", int'(cmd_col_o), e_col);
    check(oc_tag(e_oc), int'(outcome_o), e_oc);
    if (cmd_op_o >= 3) begin
      if (outcome_o == 1) seen_hit++;
      if (outcome_o == 2) seen_empty++;
      if (outcome_o == 3) seen_conf++;
    end
    v = (q.size() > 0) && !(allow_idle && m_first && ($urandom % 4 == 0));
    req_valid_i = v;
    if (v) begin
      req_bank_i = BW'(q[0].bank); req_row_i = RW'(q[0].row);
      req_col_i = CW'(q[0].col); req_write_i = q[0].wr[0];
    end
    #1;
    e_valid = 0; e_op = 0; e_bank = 0; e_row = 0; e_col = 0; e_oc = 0; e_rdy = 0;
    if (v) begin
      b = q[0].bank;
      if (m_first) begin
        m_cls = !m_open[b] ? 2 : (m_row[b] == q[0].row ? 1 : 3);
        m_first = 0;
      end
      if (m_open[b] && m_row[b] == q[0].row) begin
        if (cyc - m_lact[b] >= int'(t_rcd_i)) begin
          e_op = q[0].wr ? 4 : 3; e_oc = m_cls; e_rdy = 1; m_first = 1;
        end
      end else if (!m_open[b]) begin
        if (cyc - m_lpre[b] >= int'(t_rp_i)) begin
          e_op = 1; m_open[b] = 1; m_row[b] = q[0].row; m_lact[b] = cyc;
        end
      end else if (cyc - m_lact[b] >= int'(t_ras_i)) begin
        e_op = 2; m_open[b] = 0; m_lpre[b] = cyc;
      end
      if (e_op != 0) begin
        e_valid = 1; e_bank = b; e_row = q[0].row; e_col = q[0].col;
      end
    end
    check("R9 req_ready", int'(req_ready_o), e_rdy);
    if (e_rdy) void'(q.pop_front());
    cyc++;
  endtask

  task automatic drain(input bit allow_idle);
    while (q.size() > 0) step(allow_idle);
    step(0); step(0);
  endtask

  task automatic push(input int b, input int r, input int c, input int w);
    req_s x;
    x.bank = b; x.row = r; x.col = c; x.wr = w;
    q.push_back(x);
  endtask

  task automatic push_random(input int n);
    for (int i = 0; i < n; i++)
      push($urandom % NB, $urandom % 3, $urandom % 64, $urandom % 2);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin
      m_open[i] = 0; m_row[i] = 0; m_lact[i] = -100; m_lpre[i] = -100;
    end
    repeat (3) @(negedge clk_i);
    check("R10 reset cmd_valid", int'(cmd_valid_o), 0);
    check("R10 reset cmd_op", int'(cmd_op_o), 0);
    check("R10 reset ready", int'(req_ready_o), 0);
    t_rcd_i = 4'd3; t_rp_i = 4'd2; t_ras_i = 4'd5;
    rst_ni = 1'b1;
    // R10: idle after reset, no commands
    repeat (4) step(0);
    // R1 empty, R2 hit, R3 conflict, R4 separate banks
    push(0, 5, 1, 0); push(0, 5, 2, 1); push(0, 9, 3, 0);
    push(1, 5, 4, 1); push(0, 9, 5, 0); push(1, 3, 6, 0);
    push(2, 5, 7, 1); push(3, 7, 8, 0); push(2, 5, 9, 0);
    drain(0);
    push_random(150); drain(1);
    t_rcd_i = 4'd0; t_rp_i = 4'd0; t_ras_i = 4'd0;
    push_random(150); drain(1);
    t_rcd_i = 4'd1; t_rp_i = 4'd4; t_ras_i = 4'd7;
    push_random(150); drain(0);
    check("R2 hit seen", int'(seen_hit > 0), 1);
    check("R1 empty seen", int'(seen_empty > 0), 1);
    check("R3 conflict seen", int'(seen_conf > 0), 1);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule